// File: doc/BRIEF.md
# Stutter-Inserting Off-Chip Bus Encoder

This block sits between a core-side word stream and one narrow segment of an off-chip parallel bus. Each word from the core becomes a bus vector. Before the block drives a word, it asks an external combinational legality function whether the move from the vector now on the pins to the new one is acceptable. That function is an estimate of package noise: simultaneous switching, glitching on quiet lines and edge slowdown. If the move is acceptable, the word goes out at once with the forwarded clock enabled for one cycle.

If the move is not acceptable, the block walks the pins toward the word through intermediate stutter vectors, and the forwarded clock stays gated while they are on the bus. The receiver therefore captures only real data. Each stutter is picked greedily from the legal partial moves toward the target. All candidate vectors are queried through the same legality port, one query per cycle.

Words are held in a 32-entry queue, so stutter and search cycles lose no data. The core side is valid/ready. A word is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` falls only when the queue is full, and the core must then hold its word and keep `in_valid` high. After 32 consecutive idle cycles the queue pointers are resynchronised, and a one-cycle status pulse reports this.

Top module: `stutter_enc`

## Requirements
- R1: When the legality input accepts the move from `bus_out` to the next word, or the word equals `bus_out`, the word appears on `bus_out` with `bus_clk_en` high for exactly one cycle and no stutter before it.
- R2: Every intermediate vector placed on `bus_out` has `bus_clk_en` low; `bus_clk_en` is high only in the cycle a data word first appears.
- R3: Each stutter applies one change mask that is a proper subset of the bits still differing from the target. The mask chosen is the legal one with the most set bits, and among equals the numerically lowest. If no such mask is legal, the lowest differing bit alone is flipped.
- R4: A single word is preceded by at most W stutter vectors, which is within the bound of 2·(W−1) stutters for W of 2 or more.
- R5: The queue holds 32 words. `in_ready` is low exactly when 32 words are held. Accepted words leave in arrival order, with none lost or duplicated.
- R6: With no word pending, `bus_out` repeats its last value and `bus_clk_en` stays low.
- R7: After 32 consecutive cycles with `in_valid` low, the queue empty and no word in progress, `idle_rst` pulses high for one cycle. It pulses only once per idle run, and the queue pointers are cleared at that point without affecting later traffic.
- R8: After reset, `bus_out` is all zeros, `bus_clk_en` and `idle_rst` are low and `in_ready` is high.
- R9: Every change of `bus_out` is a move that the legality input accepted in the cycle before it, except for the forced single-bit moves of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Core word valid |
| in_ready | output | 1 | Queue can accept a word |
| in_data | input | W | Core word |
| bus_out | output | W | Vector driven onto the bus segment |
| bus_clk_en | output | 1 | Enable for the forwarded clock, high only on data vectors |
| chk_from | output | W | Present vector offered to the legality function |
| chk_to | output | W | Candidate vector offered to the legality function |
| chk_legal | input | 1 | Same-cycle verdict of the legality function |
| idle_rst | output | 1 | One-cycle pulse when the idle resynchronisation happens |

## Verification
The words are tried under three legality rules.

- **At most one rising and one falling line.** Short moves pass directly. Full swings such as 0000↔1111 need single-bit stutters, and complementary pairs such as 0011→1100 need a mixed two-bit stutter. This separates correct greedy ordering from a plain bit-by-bit walk.
- **At most two changed lines.** This shows that wider legal masks are preferred over narrower ones.
- **Reject everything.** This drives the forced lowest-bit path and the longest stutter chains.

A burst of full swings fills the queue to show back-pressure. A quiet spell after traffic checks the exact idle pulse timing, and a word sent after it shows that traffic continues normally.

// File: rtl/stutter_pkg.sv
package stutter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DIRECT = 2'd1,
    ST_SCAN   = 2'd2
  } seq_st_t;

endpackage

// File: rtl/stutter_fifo.sv
module stutter_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   CAP  = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CAP);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/stutter_seq.sv
module stutter_seq
  import stutter_pkg::*;
#(
  parameter int W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     have_word,
  input  logic [W-1:0]             head,
  output logic                     pop,
  output logic [W-1:0]             cand,
  input  logic                     cand_ok,
  output logic [W-1:0]             bus,
  output logic                     bus_en,
  output seq_st_t                  st,
  output logic [$clog2(W+2)-1:0]   stut_cnt
);
  localparam int PCW = $clog2(W+1);
  localparam int SCW = $clog2(W+2);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  seq_st_t        st_n;
  logic [W-1:0]   bus_n, tgt, tgt_n, mask, mask_n, best, best_n;
  logic [PCW-1:0] best_pc, best_pc_n, mask_pc;
  logic [SCW-1:0] stut_n;
  logic           bus_en_n;
  logic [W-1:0]   diff_h, diff_t, step, pick;
  logic           good, last_step;

  assign diff_h  = bus ^ head;
  assign diff_t  = bus ^ tgt;
  assign mask_pc = PCW'($countones(mask));
  assign step    = (mask - diff_t) & diff_t;

  always_comb begin
    st_n      = st;
    bus_n     = bus;
    bus_en_n  = 1'b0;
    tgt_n     = tgt;
    mask_n    = mask;
    best_n    = best;
    best_pc_n = best_pc;
    stut_n    = stut_cnt;
    pop       = 1'b0;
    cand      = bus;
    good      = 1'b0;
    last_step = 1'b0;
    pick      = '0;
    case (st)
      ST_IDLE: begin
        cand = head;
        if (have_word) begin
          pop = 1'b1;
          if (cand_ok || (head == bus)) begin
            bus_n    = head;
            bus_en_n = 1'b1;
            stut_n   = '0;
          end else begin
            tgt_n     = head;
            mask_n    = diff_h & (~diff_h + ONE);
            best_n    = '0;
            best_pc_n = '0;
            st_n      = ST_SCAN;
          end
        end
      end
      ST_DIRECT: begin
        cand = tgt;
        if (cand_ok || (tgt == bus)) begin
          bus_n    = tgt;
          bus_en_n = 1'b1;
          stut_n   = '0;
          st_n     = ST_IDLE;
        end else begin
          mask_n    = diff_t & (~diff_t + ONE);
          best_n    = '0;
          best_pc_n = '0;
          st_n      = ST_SCAN;
        end
      end
      ST_SCAN: begin
        cand = bus ^ mask;
        good = cand_ok && (mask_pc > best_pc);
        if (good) begin
          best_n    = mask;
          best_pc_n = mask_pc;
        end
        last_step = (step == '0) || (step == diff_t);
        if (last_step) begin
          if (good)                 pick = mask;
          else if (best_pc != '0)   pick = best;
          else                      pick = diff_t & (~diff_t + ONE);
          bus_n  = bus ^ pick;
          stut_n = stut_cnt + 1'b1;
          st_n   = ST_DIRECT;
        end else begin
          mask_n = step;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bus      <= '0;
      bus_en   <= 1'b0;
      tgt      <= '0;
      mask     <= '0;
      best     <= '0;
      best_pc  <= '0;
      stut_cnt <= '0;
    end else begin
      st       <= st_n;
      bus      <= bus_n;
      bus_en   <= bus_en_n;
      tgt      <= tgt_n;
      mask     <= mask_n;
      best     <= best_n;
      best_pc  <= best_pc_n;
      stut_cnt <= stut_n;
    end
  end
endmodule

// File: rtl/stutter_idle.sv
module stutter_idle #(
  parameter int LIM = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  output logic fire,
  output logic pulse
);
  localparam int CW = $clog2(LIM + 1);
  localparam logic [CW-1:0] TOP  = CW'(LIM);
  localparam logic [CW-1:0] PRE  = CW'(LIM - 1);

  logic [CW-1:0] cnt;

  assign fire = idle && (cnt == PRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= fire;
      if (!idle)          cnt <= '0;
      else if (cnt != TOP) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/stutter_enc.sv
module stutter_enc
  import stutter_pkg::*;
#(
  parameter int W        = 4,
  parameter int DEPTH    = 32,
  parameter int IDLE_LIM = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] bus_out,
  output logic         bus_clk_en,
  output logic [W-1:0] chk_from,
  output logic [W-1:0] chk_to,
  input  logic         chk_legal,
  output logic         idle_rst
);
  localparam int AW  = $clog2(DEPTH);
  localparam int SCW = $clog2(W + 2);

  logic               q_empty, q_full, q_pop, flush, idle;
  logic [W-1:0]       q_head;
  logic [AW:0]        fifo_cnt;
  seq_st_t            seq_st;
  logic [SCW-1:0]     stut_cnt;

  assign in_ready = !q_full;
  assign chk_from = bus_out;
  assign idle     = !in_valid && q_empty && (seq_st == ST_IDLE);

  stutter_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (in_valid),
    .din   (in_data),
    .pop   (q_pop),
    .dout  (q_head),
    .empty (q_empty),
    .full  (q_full),
    .cnt   (fifo_cnt)
  );

  stutter_seq #(.W(W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .have_word (!q_empty),
    .head      (q_head),
    .pop       (q_pop),
    .cand      (chk_to),
    .cand_ok   (chk_legal),
    .bus       (bus_out),
    .bus_en    (bus_clk_en),
    .st        (seq_st),
    .stut_cnt  (stut_cnt)
  );

  stutter_idle #(.LIM(IDLE_LIM)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .idle  (idle),
    .fire  (flush),
    .pulse (idle_rst)
  );
endmodule

// File: rtl/stutter_enc_chk.sv
module stutter_enc_chk
  import stutter_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_ready,
  input logic [W-1:0]             bus_out,
  input logic                     bus_clk_en,
  input logic                     idle_rst,
  input seq_st_t                  seq_st,
  input logic [$clog2(W+2)-1:0]   stut_cnt,
  input logic [$clog2(DEPTH):0]   fifo_cnt
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R2
  gated_stutter_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (!bus_clk_en && (bus_out != $past(bus_out))) |-> ($past(seq_st) == ST_SCAN));

  // R1
  data_source_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    bus_clk_en |-> ($past(seq_st) != ST_SCAN));

  // R4
  stutter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stut_cnt <= ($clog2(W+2))'(W));

  // R5
  fifo_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= ($clog2(DEPTH)+1)'(DEPTH));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (fifo_cnt <= $past(fifo_cnt)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_st == ST_IDLE && fifo_cnt == '0) |=> $stable(bus_out));

  // R7
  idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_rst |=> !idle_rst);
endmodule

bind stutter_enc stutter_enc_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .bus_out    (bus_out),
  .bus_clk_en (bus_clk_en),
  .idle_rst   (idle_rst),
  .seq_st     (seq_st),
  .stut_cnt   (stut_cnt),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/stutter_enc_tb.sv
module stutter_enc_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] bus_out, chk_from, chk_to;
  logic         bus_clk_en, chk_legal, idle_rst;
  int           lmode = 0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_en = 0, gcnt = 0, npulse = 0;
  bit arm = 0, saw_full = 0, prev_pulse = 0, done = 0;
  logic [W-1:0] prev_bus = '0, model_cur = '0;
  logic [W:0]   exp_q[$];

  always #10 clk = ~clk;

  stutter_enc #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .bus_out(bus_out), .bus_clk_en(bus_clk_en),
    .chk_from(chk_from), .chk_to(chk_to), .chk_legal(chk_legal),
    .idle_rst(idle_rst));

  function automatic bit legal_f(input logic [W-1:0] a, input logic [W-1:0] b, input int md);
    int r, f;
    r = $countones(~a & b);
    f = $countones(a & ~b);
    if (md == 0) return (r <= 1) && (f <= 1);
    if (md == 2) return (r + f) <= 2;
    return 1'b0;
  endfunction

  always_comb chk_legal = legal_f(chk_from, chk_to, lmode);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Expected path per word: stutters (flag 0) then the word (flag 1).
  task automatic model(input logic [W-1:0] t);
    logic [W-1:0] c, d, best;
    int bpc;
    c = model_cur;
    forever begin
      if (c == t || legal_f(c, t, lmode)) begin
        exp_q.push_back({1'b1, t});
        break;
      end
      d = c ^ t;
      best = '0;
      bpc = 0;
      for (int m = 1; m < (1 << W); m++) begin
        if (((W'(m) & ~d) == '0) && (W'(m) != d) &&
            legal_f(c, c ^ W'(m), lmode) && ($countones(W'(m)) > bpc)) begin
          best = W'(m);
          bpc = $countones(W'(m));
        end
      end
      if (bpc == 0) best = d & (~d + 1'b1);
      c = c ^ best;
      exp_q.push_back({1'b0, c});
    end
    model_cur = t;
  endtask

  task automatic send(input logic [W-1:0] d);
    bit ok;
    model(d);
    in_valid = 1'b1;
    in_data  = d;
    forever begin
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [W:0] e;
      cyc++;
      if (!in_ready) saw_full = 1;
      if (bus_out !== prev_bus || bus_clk_en) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6 unexpected bus activity", int'(bus_out), int'(prev_bus));
        end else begin
          e = exp_q.pop_front();
          chk(bus_out == e[W-1:0], e[W] ? "R1 data vector" : "R3 stutter vector",
              int'(bus_out), int'(e[W-1:0]));
          chk(bus_clk_en == e[W], "R2 clock enable", int'(bus_clk_en), int'(e[W]));
        end
        if (bus_clk_en) begin
          chk(gcnt <= W, "R4 stutter count", gcnt, W);
          gcnt = 0;
          last_en = cyc;
        end else begin
          gcnt++;
        end
        if (bus_out !== prev_bus && lmode != 1)
          chk(legal_f(prev_bus, bus_out, lmode), "R9 pair legality",
              int'(bus_out), int'(prev_bus));
      end
      if (idle_rst) begin
        chk(!prev_pulse, "R7 pulse width", 2, 1);
        if (arm) begin
          npulse++;
          chk(cyc - last_en == 32, "R7 idle pulse timing", cyc - last_en, 32);
        end
      end
      prev_pulse = idle_rst;
      prev_bus = bus_out;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(bus_out == '0, "R8 bus after reset", int'(bus_out), 0);
    chk(!bus_clk_en, "R8 clock enable after reset", int'(bus_clk_en), 0);
    chk(in_ready, "R8 ready after reset", int'(in_ready), 1);
    chk(!idle_rst, "R8 idle pulse after reset", int'(idle_rst), 0);

    // R1: directly legal moves, including a repeated word
    lmode = 0;
    send(4'h1); send(4'h3); send(4'h2); send(4'h6);
    send(4'h4); send(4'h4); send(4'hC); send(4'h8);
    drain();

    // R3: swings and complementary pairs under the one-rise-one-fall rule
    send(4'hF); send(4'h0); send(4'h3); send(4'hC);
    send(4'h5); send(4'hA); send(4'h9); send(4'h6);
    drain();

    // R5: back-to-back full swings to fill the queue
    for (int i = 0; i < 40; i++) send((i % 2 == 0) ? 4'hF : 4'h0);
    chk(saw_full, "R5 ready dropped when queue full", int'(saw_full), 1);
    drain();

    // R3: wider masks preferred under the two-line rule
    lmode = 2;
    send(4'hF); send(4'h0); send(4'h7); send(4'h8); send(4'hE);
    drain();

    // R3/R4: nothing legal, forced lowest-bit moves
    lmode = 1;
    send(4'h0); send(4'hF); send(4'h0); send(4'hA);
    drain();

    // R6: quiet bus holds
    begin
      logic [W-1:0] held;
      held = bus_out;
      arm = 1;
      repeat (10) @(negedge clk);
      chk(bus_out == held, "R6 bus held while idle", int'(bus_out), int'(held));
      chk(!bus_clk_en, "R6 clock gated while idle", int'(bus_clk_en), 0);
    end

    // R7: one pulse per idle run, traffic fine afterwards
    repeat (60) @(negedge clk);
    chk(npulse == 1, "R7 pulses per idle run", npulse, 1);
    arm = 0;
    lmode = 0;
    send(4'h3); send(4'h7);
    drain();

    chk(exp_q.size() == 0, "R5 all words delivered", exp_q.size(), 0);
    done = 1;
    summary();
  end
endmodule